// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Detection

This block is one 32-pin general-purpose I/O port on a simple word-wide register bus. Software drives pins through a data-out register gated per pin by an output-enable register. It reads the pin states back through a synchronized data-in register. Each pin can also be routed to interrupt detection, which catches a rising edge, a falling edge, a high level or a low level into a sticky status bit.

Every writable register has three write addresses: one replaces the whole value, one ORs a mask in, and one clears the bits named by a mask. Software can therefore change single pins without a read-modify-write. Status bits are set only by hardware and cleared only through their clear address. The port raises one interrupt line whenever an enabled status bit is pending.

Top module: `gpio_irq_port`

## Requirements
- R1: Register index is address bits [10:8]: 0 data-out, 1 data-in, 2 output-enable, 3 interrupt select, 4 interrupt enable, 5 level select, 6 polarity, 7 status. Bits [3:2] pick the write operation: 0 replace, 1 set (OR mask, address +0x4), 2 clear (AND NOT mask, address +0x8), 3 no effect. A write is accepted only when bits [11], [7:4] and [1:0] are zero. Reads return the register selected by bits [10:8], whatever bits [3:2] hold.
- R2: A write to a register's set address ORs the written data into it, leaving the other bits unchanged.
- R3: A write to a register's clear address clears exactly the bits that are 1 in the written data.
- R4: After reset, every register reads 0 (data-in reads 0 while the pins are low), both pad outputs are 0 and the interrupt is low.
- R5: pad_oe_o equals output-enable, and pad_out_o equals data-out AND output-enable.
- R6: Data-in returns the pins after a two-flop synchronizer: a pin change made between clock edges reads back after the second rising edge and not after the first. Writes to data-in have no effect.
- R7: Per pin, the pair (polarity, level) selects 00 falling edge, 01 low level, 10 rising edge, 11 high level. A detected event sets the status bit on the rising edge after the synchronized value shows it, which is the third edge after a pin change.
- R8: Status bits are sticky. Only a write to the status clear address removes them; writes to the status replace and set addresses have no effect.
- R9: A level-sensitive pin sets its status on every cycle its level is active, so a clear does not remove it while the level persists. An event and a clear in the same cycle leave the bit set.
- R10: A pin with interrupt select 0 never sets status.
- R11: irq_o is 1 exactly when some bit of (status AND interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 12 | Byte address for write and read |
| bus_wdata_i | input | 32 | Write data or mask |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| pin_in_i | input | 32 | Asynchronous pin levels |
| pad_out_o | output | 32 | Pad output value, zero where not enabled |
| pad_oe_o | output | 32 | Pad output enable |
| irq_o | output | 1 | Combined port interrupt |

## Verification
A hardware status set and a software clear of the same bit can land on the same clock edge. The bench provokes this by changing a rising-edge pin and timing a status clear write so that it is registered on the third edge after the change, which is the edge where the event is captured. The bit is judged correct if it still reads 1 after that edge. A later clear with no new edge must remove it. The same collision with a held active level is checked by clearing while the level persists and expecting the level-sensitive bits to remain.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_IDX_W = 3;
  localparam int NUM_CFG   = 6;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_DOUT = 3'd0,
    RG_DIN  = 3'd1,
    RG_DOE  = 3'd2,
    RG_SEL  = 3'd3,
    RG_EN   = 3'd4,
    RG_LEV  = 3'd5,
    RG_POL  = 3'd6,
    RG_STAT = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } wr_op_e;

  // Map a configuration storage slot to its register index.
  function automatic reg_idx_e cfg_slot_reg(input int slot);
    case (slot)
      0:       return RG_DOUT;
      1:       return RG_DOE;
      2:       return RG_SEL;
      3:       return RG_EN;
      4:       return RG_LEV;
      default: return RG_POL;
    endcase
  endfunction

  // New value of one register bit under a bus write operation.
  function automatic logic op_bit(input logic old_v, input logic mask_v,
                                  input wr_op_e op);
    case (op)
      OP_WRITE: return mask_v;
      OP_SET:   return old_v | mask_v;
      OP_CLR:   return old_v & ~mask_v;
      default:  return old_v;
    endcase
  endfunction

  // Detection for one pin: lev=1 level mode, pol=1 high/rising.
  function automatic logic pin_evt_bit(input logic now_v, input logic prev_v,
                                       input logic lev, input logic pol);
    logic r;
    if (lev) r = pol ? now_v : ~now_v;
    else     r = pol ? (now_v & ~prev_v) : (~now_v & prev_v);
    return r;
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  input  reg_idx_e                    wr_idx,
  input  wr_op_e                      wr_op,
  input  logic [W-1:0]                wdata,
  output logic [NUM_CFG-1:0][W-1:0]   cfg_q
);

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_slot
    logic hit;
    assign hit = wr_valid && (wr_idx == cfg_slot_reg(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[k] <= '0;
      end else if (hit) begin
        for (int b = 0; b < W; b++) begin
          cfg_q[k][b] <= op_bit(cfg_q[k][b], wdata[b], wr_op);
        end
      end
    end
  end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
      prev_q <= chain_q[LAST];
    end
  end

  assign sync_o = chain_q[LAST];
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] lev_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] evt_o
);

  for (genvar b = 0; b < W; b++) begin : g_pin
    assign evt_o[b] = sel_i[b] &
                      pin_evt_bit(sync_i[b], prev_i[b], lev_i[b], pol_i[b]);
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);

  logic [W-1:0] stat_q;

  // Event has priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_i) | evt_i;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);

  localparam int IDX_LSB = 8;
  localparam int IDX_MSB = IDX_LSB + REG_IDX_W - 1;
  localparam int OP_LSB  = 2;
  localparam int OP_MSB  = OP_LSB + 1;

  // Address decode
  logic     addr_ok;
  logic     wr_valid;
  reg_idx_e wr_idx;
  wr_op_e   wr_op;

  assign addr_ok  = (bus_addr_i[ADDR_W-1:IDX_MSB+1] == '0) &&
                    (bus_addr_i[IDX_LSB-1:OP_MSB+1] == '0) &&
                    (bus_addr_i[OP_LSB-1:0] == '0);
  assign wr_idx   = reg_idx_e'(bus_addr_i[IDX_MSB:IDX_LSB]);
  assign wr_op    = wr_op_e'(bus_addr_i[OP_MSB:OP_LSB]);
  assign wr_valid = bus_wr_i && addr_ok;

  // Configuration registers
  logic [NUM_CFG-1:0][NUM_PINS-1:0] cfg_q;
  logic [NUM_PINS-1:0] dout_q, doe_q, sel_q, en_q, lev_q, pol_q;

  gpio_cfg_regs #(.W(NUM_PINS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_idx   (wr_idx),
    .wr_op    (wr_op),
    .wdata    (bus_wdata_i),
    .cfg_q    (cfg_q)
  );

  assign dout_q = cfg_q[0];
  assign doe_q  = cfg_q[1];
  assign sel_q  = cfg_q[2];
  assign en_q   = cfg_q[3];
  assign lev_q  = cfg_q[4];
  assign pol_q  = cfg_q[5];

  // Input synchronizer
  logic [NUM_PINS-1:0] pin_sync, pin_prev;

  gpio_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_in_i),
    .sync_o (pin_sync),
    .prev_o (pin_prev)
  );

  // Event detection
  logic [NUM_PINS-1:0] evt_vec;

  gpio_irq_detect #(.W(NUM_PINS)) u_det (
    .sync_i (pin_sync),
    .prev_i (pin_prev),
    .sel_i  (sel_q),
    .lev_i  (lev_q),
    .pol_i  (pol_q),
    .evt_o  (evt_vec)
  );

  // Sticky status, cleared only through the clear address
  logic                stat_clr_hit;
  logic [NUM_PINS-1:0] stat_clr_mask;
  logic [NUM_PINS-1:0] stat_q;

  assign stat_clr_hit  = wr_valid && (wr_idx == RG_STAT) && (wr_op == OP_CLR);
  assign stat_clr_mask = stat_clr_hit ? bus_wdata_i : '0;

  gpio_irq_status #(.W(NUM_PINS)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_vec),
    .clr_i  (stat_clr_mask),
    .stat_o (stat_q)
  );

  // Outputs
  logic [NUM_PINS-1:0] pend_vec;
  assign pend_vec  = stat_q & en_q;
  assign irq_o     = |pend_vec;
  assign pad_oe_o  = doe_q;
  assign pad_out_o = dout_q & doe_q;

  always_comb begin
    case (wr_idx)
      RG_DOUT: bus_rdata_o = dout_q;
      RG_DIN:  bus_rdata_o = pin_sync;
      RG_DOE:  bus_rdata_o = doe_q;
      RG_SEL:  bus_rdata_o = sel_q;
      RG_EN:   bus_rdata_o = en_q;
      RG_LEV:  bus_rdata_o = lev_q;
      RG_POL:  bus_rdata_o = pol_q;
      default: bus_rdata_o = stat_q;
    endcase
  end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_valid,
  input reg_idx_e     wr_idx,
  input wr_op_e       wr_op,
  input logic [W-1:0] wdata,
  input logic [W-1:0] dout_q,
  input logic [W-1:0] sel_q,
  input logic [W-1:0] en_q,
  input logic [W-1:0] stat_q,
  input logic [W-1:0] stat_clr_mask,
  input logic [W-1:0] evt_vec,
  input logic [W-1:0] pad_out_o,
  input logic [W-1:0] pad_oe_o,
  input logic         irq_o
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_SET_ALIAS_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_valid && wr_idx == RG_DOUT && wr_op == OP_SET)
    |=> ((dout_q & $past(wdata)) == $past(wdata))); // R2

  AST_CLR_ALIAS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_valid && wr_idx == RG_DOUT && wr_op == OP_CLR)
    |=> ((dout_q & $past(wdata)) == '0)); // R3

  AST_PAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out_o & ~pad_oe_o) == '0)); // R5

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> (($past(stat_q) & ~$past(stat_clr_mask) & ~stat_q) == '0)); // R8

  AST_STAT_SET_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> ((stat_q & ~$past(stat_q) & ~$past(evt_vec)) == '0)); // R8

  AST_STAT_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> ((stat_q & ~$past(stat_q) & ~$past(sel_q)) == '0)); // R10

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o); // R11

  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq_o); // R11

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(NUM_PINS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .wr_idx        (wr_idx),
  .wr_op         (wr_op),
  .wdata         (bus_wdata_i),
  .dout_q        (dout_q),
  .sel_q         (sel_q),
  .en_q          (en_q),
  .stat_q        (stat_q),
  .stat_clr_mask (stat_clr_mask),
  .evt_vec       (evt_vec),
  .pad_out_o     (pad_out_o),
  .pad_oe_o      (pad_oe_o),
  .irq_o         (irq_o)
);

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pins = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .pin_in_i    (pins),
    .pad_out_o   (pad_out),
    .pad_oe_o    (pad_oe),
    .irq_o       (irq)
  );

  // Register indices and operation offsets (R1)
  localparam int I_DOUT = 0, I_DIN = 1, I_DOE = 2, I_SEL = 3,
                 I_EN = 4, I_LEV = 5, I_POL = 6, I_STAT = 7;
  localparam int OFS_SET = 'h4, OFS_CLR = 'h8;

  function automatic logic [11:0] a_of(int idx, int ofs);
    return 12'(idx * 'h100 + ofs);
  endfunction

  // Pins whose index mod 4 equals the encoding {pol,lev}
  function automatic logic [N-1:0] enc_mask(int e);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) if ((i % 4) == e) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(logic [N-1:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] fe, ll, re, hl;
    int rw_list [6] = '{I_DOUT, I_DOE, I_SEL, I_EN, I_LEV, I_POL};
    fe = enc_mask(0); ll = enc_mask(1); re = enc_mask(2); hl = enc_mask(3);

    idle(3);
    // R4: reset state
    for (int r = 0; r < 8; r++) begin
      rd(a_of(r, 0), v);
      check("R4 reset reg", v, '0);
    end
    check("R4 reset pad_out", pad_out, '0);
    check("R4 reset pad_oe", pad_oe, '0);
    check("R4 reset irq", {31'b0, irq}, '0);
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R3: replace, set and clear on each writable register
    for (int k = 0; k < 6; k++) begin
      logic [N-1:0] base;
      base = 32'hA5A5_0F0F ^ (32'h1111_1111 * k);
      wr(a_of(rw_list[k], 0), base);
      rd(a_of(rw_list[k], 0), v);
      check("R1 replace write", v, base);
      wr(a_of(rw_list[k], OFS_SET), 32'h00F0_F000);
      rd(a_of(rw_list[k], OFS_SET), v);
      check("R2 set alias", v, base | 32'h00F0_F000);
      wr(a_of(rw_list[k], OFS_CLR), 32'h0F00_000F);
      rd(a_of(rw_list[k], 0), v);
      check("R3 clear alias", v, (base | 32'h00F0_F000) & ~32'h0F00_000F);
      wr(a_of(rw_list[k], 'hC), '0);
      rd(a_of(rw_list[k], 0), v);
      check("R1 op 3 no effect", v, (base | 32'h00F0_F000) & ~32'h0F00_000F);
      wr(a_of(rw_list[k], 0) | 12'h010, 32'h1234_5678);
      rd(a_of(rw_list[k], 0), v);
      check("R1 bad address ignored", v, (base | 32'h00F0_F000) & ~32'h0F00_000F);
    end

    // R5: pad gating
    wr(a_of(I_DOUT, 0), 32'hDEAD_BEEF);
    wr(a_of(I_DOE, 0), 32'hFF00_FF00);
    idle(1);
    check("R5 pad_oe", pad_oe, 32'hFF00_FF00);
    check("R5 pad_out", pad_out, 32'hDEAD_BEEF & 32'hFF00_FF00);

    // Clear all interrupt configuration and status
    for (int k = 2; k < 6; k++) wr(a_of(rw_list[k], 0), '0);
    wr(a_of(I_STAT, OFS_CLR), '1);

    // R6: synchronizer latency and ignored writes
    set_pins(32'h3C5A_9617);
    rd(a_of(I_DIN, 0), v);
    check("R6 din after one edge", v, '0);
    rd(a_of(I_DIN, 0), v);
    check("R6 din after two edges", v, 32'h3C5A_9617);
    wr(a_of(I_DIN, 0), 32'hFFFF_0000);
    wr(a_of(I_DIN, OFS_CLR), '1);
    rd(a_of(I_DIN, 0), v);
    check("R6 din write ignored", v, 32'h3C5A_9617);
    set_pins('0);
    idle(3);

    // R7: mode sweep, pin i uses encoding i mod 4
    wr(a_of(I_LEV, 0), ll | hl);
    wr(a_of(I_POL, 0), re | hl);
    wr(a_of(I_STAT, OFS_CLR), '1);
    rd(a_of(I_STAT, 0), v);
    check("R10 no status without select", v, '0);
    wr(a_of(I_SEL, 0), '1);
    idle(2);
    rd(a_of(I_STAT, 0), v);
    check("R7 low level sets", v, ll);
    set_pins('1);
    idle(3);
    rd(a_of(I_STAT, 0), v);
    check("R7 rising and high", v, ll | re | hl);
    wr(a_of(I_STAT, OFS_CLR), '1);
    rd(a_of(I_STAT, 0), v);
    check("R9 high level survives clear", v, hl);
    set_pins('0);
    idle(3);
    rd(a_of(I_STAT, 0), v);
    check("R7 falling and low", v, hl | fe | ll);
    wr(a_of(I_STAT, OFS_CLR), '1);
    rd(a_of(I_STAT, 0), v);
    check("R9 low level survives clear", v, ll);

    // R8: base and set writes to status ignored
    wr(a_of(I_STAT, 0), '1);
    rd(a_of(I_STAT, 0), v);
    check("R8 status base write ignored", v, ll);
    wr(a_of(I_STAT, OFS_SET), '1);
    rd(a_of(I_STAT, 0), v);
    check("R8 status set write ignored", v, ll);
    idle(4);
    rd(a_of(I_STAT, 0), v);
    check("R8 status holds", v, ll);

    // R11: combined interrupt
    wr(a_of(I_EN, 0), '0);
    check("R11 irq low, no enable", {31'b0, irq}, '0);
    wr(a_of(I_EN, 0), ~ll);
    check("R11 irq low, disjoint enable", {31'b0, irq}, '0);
    wr(a_of(I_EN, OFS_SET), 32'h0000_0020);
    check("R11 irq high, one match", {31'b0, irq}, 32'd1);
    wr(a_of(I_EN, 0), '0);

    // R10: deselected pins do not raise status
    wr(a_of(I_SEL, 0), '0);
    wr(a_of(I_STAT, OFS_CLR), '1);
    set_pins('1);
    idle(3);
    set_pins('0);
    idle(3);
    rd(a_of(I_STAT, 0), v);
    check("R10 deselected toggles", v, '0);

    // R9: rising event and clear on the same edge
    wr(a_of(I_SEL, 0), re);
    wr(a_of(I_STAT, OFS_CLR), '1);
    set_pins('1);
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a_of(I_STAT, OFS_CLR); bus_wdata = '1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(a_of(I_STAT, 0), v);
    check("R9 set wins over clear", v, re);
    wr(a_of(I_STAT, OFS_CLR), '1);
    rd(a_of(I_STAT, 0), v);
    check("R8 edge bit clears", v, '0);
    wr(a_of(I_EN, 0), re);
    check("R11 irq low after clear", {31'b0, irq}, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule